// File: doc/BRIEF.md
# Snooze Power-State Controller

This controller sits between a synchronous memory's pins and its core. It decides when the memory is in a low-power retention state. The request arrives on an asynchronous snooze pin. That pin passes through a flop synchroniser and must then hold its level for a set number of clocks before the controller acts on it. While the memory sleeps, the clock keeps running and stored contents stay in place. The controller closes the gate on every other input: both start strobes and the control bus reach the core as zero. It also keeps the data pins in high impedance, whatever the output-enable pin says.

When the pin has been low long enough, the controller wakes. It reopens the input gate at once, but holds a start-inhibit for a recovery window so that neither start strobe can begin an access too early. Entry delay, exit delay and recovery length are clock-count parameters. The defaults are sized for a 100 MHz clock: entry completes within 100 ns, and recovery lasts 100 ns.

The control is a five-state machine:
- AWAKE, the normal state.
- ENTERING, counting a stable high level. It returns to AWAKE if snooze drops; once the count is met it moves to ASLEEP.
- ASLEEP. It moves to WAKING when snooze goes low.
- WAKING, counting a stable low level. It returns to ASLEEP if snooze rises; once the count is met it moves to RECOVERING.
- RECOVERING, the start lockout. When its count ends it moves to AWAKE, whatever the snooze level.

Top module: `snz_power_ctl`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and right after it, the block is AWAKE: `sleep_flag`=0, `gate_en`=1, `start_inhibit`=0.
- R2: With `SYNC_STAGES`=2 and `ENTER_CYC`=6, suppose `snooze_in` rises and then stays high. `sleep_flag` is still 0 after the 8th rising clock edge that follows the change, and is 1 after the 9th.
- R3: A high pulse on `snooze_in` that is too short leaves the block awake. A pulse that the core sees high for fewer than `ENTER_CYC` cycles ends with `sleep_flag`=0 and `gate_en`=1.
- R4: While `sleep_flag`=1, the block isolates the core: `gate_en`=0, `ctl_pass` is all zero, `start_pass_a`=`start_pass_b`=0, and `dq_drive`=0 for either level of `oe_in`.
- R5: With `EXIT_CYC`=6, suppose `snooze_in` falls and then stays low. `sleep_flag` is still 1 after the 8th rising edge and is 0 after the 9th. A low pulse shorter than that leaves `sleep_flag` at 1.
- R6: When `sleep_flag` falls, `gate_en` becomes 1 and `start_inhibit` stays 1 for exactly `RECOVER_CYC` (10) cycles. Both start strobes are blocked during that window.
- R7: A rise of `snooze_in` during recovery does not shorten it. `start_inhibit` still falls on schedule, and entry to sleep then follows through ENTERING.
- R8: While AWAKE: `ctl_pass` equals `ctl_in`, each `start_pass_*` equals its strobe, and `dq_drive` equals `oe_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, running in every state |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze_in | input | 1 | Asynchronous low-power request |
| oe_in | input | 1 | Asynchronous output-enable request from the read path |
| strobe_a | input | 1 | First start strobe |
| strobe_b | input | 1 | Second start strobe |
| ctl_in | input | CTL_W | Other synchronous control inputs |
| sleep_flag | output | 1 | 1 in ASLEEP and WAKING |
| gate_en | output | 1 | 1 when inputs may reach the core |
| start_inhibit | output | 1 | 1 in ASLEEP, WAKING and RECOVERING |
| start_pass_a | output | 1 | Gated first start strobe |
| start_pass_b | output | 1 | Gated second start strobe |
| ctl_pass | output | CTL_W | Gated control inputs |
| dq_drive | output | 1 | Data pin drive enable; 0 means high impedance |

## Verification
The assertions take for granted that `snooze_in` changes far enough from a clock edge that the first synchroniser flop settles to the new level within one cycle. Under that assumption, every rise and fall of `sleep_flag` follows a matching synchronised level. The assertions also take all three count parameters to be at least one. The bench therefore changes `snooze_in` and the other inputs only 2 ns after a rising edge. It counts edges from that point, so every expected transition lands on a known edge.

// File: rtl/snz_pkg.sv
package snz_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_ENTERING,
        ST_ASLEEP,
        ST_WAKING,
        ST_RECOVERING
    } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_async;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/snz_timer.sv
module snz_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            count <= '0;
        else if (clr)          count <= '0;
        else if (count != '1)  count <= count + 1'b1;
    end
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
    import snz_pkg::*;
#(
    parameter int ENTER_CYC   = 6,
    parameter int EXIT_CYC    = 6,
    parameter int RECOVER_CYC = 10,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snz_s,
    input  logic [CNT_W-1:0] count,
    output logic             clr,
    output logic             sleeping,
    output logic             inhibit
);
    localparam logic [CNT_W-1:0] ENTER_LAST   = CNT_W'(ENTER_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST    = CNT_W'(EXIT_CYC - 1);
    localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_CYC - 1);

    snz_state_e state, next;

    always_comb begin
        next = state;
        unique case (state)
            ST_AWAKE:      if (snz_s) next = ST_ENTERING;
            ST_ENTERING:   if (!snz_s) next = ST_AWAKE;
                           else if (count == ENTER_LAST) next = ST_ASLEEP;
            ST_ASLEEP:     if (!snz_s) next = ST_WAKING;
            ST_WAKING:     if (snz_s) next = ST_ASLEEP;
                           else if (count == EXIT_LAST) next = ST_RECOVERING;
            ST_RECOVERING: if (count == RECOVER_LAST) next = ST_AWAKE;
            default:       next = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= next;
    end

    always_comb begin
        clr      = (next != state);
        sleeping = 1'b0;
        inhibit  = 1'b0;
        unique case (state)
            ST_AWAKE, ST_ENTERING: ;
            ST_ASLEEP, ST_WAKING: begin
                sleeping = 1'b1;
                inhibit  = 1'b1;
            end
            ST_RECOVERING: inhibit = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/snz_power_ctl.sv
module snz_power_ctl #(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 6,
    parameter int EXIT_CYC    = 6,
    parameter int RECOVER_CYC = 10,
    parameter int CTL_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snooze_in,
    input  logic             oe_in,
    input  logic             strobe_a,
    input  logic             strobe_b,
    input  logic [CTL_W-1:0] ctl_in,
    output logic             sleep_flag,
    output logic             gate_en,
    output logic             start_inhibit,
    output logic             start_pass_a,
    output logic             start_pass_b,
    output logic [CTL_W-1:0] ctl_pass,
    output logic             dq_drive
);
    localparam int MAX_AB = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
    localparam int MAX_C  = (MAX_AB > RECOVER_CYC) ? MAX_AB : RECOVER_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic             snooze_sync;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_count;

    snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (snooze_in),
        .q_sync  (snooze_sync)
    );

    snz_timer #(.WIDTH(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .count (tmr_count)
    );

    snz_fsm #(
        .ENTER_CYC   (ENTER_CYC),
        .EXIT_CYC    (EXIT_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .snz_s    (snooze_sync),
        .count    (tmr_count),
        .clr      (tmr_clr),
        .sleeping (sleep_flag),
        .inhibit  (start_inhibit)
    );

    assign gate_en      = ~sleep_flag;
    assign start_pass_a = strobe_a & ~start_inhibit;
    assign start_pass_b = strobe_b & ~start_inhibit;
    assign ctl_pass     = gate_en ? ctl_in : '0;
    assign dq_drive     = oe_in & ~sleep_flag;
endmodule

// File: rtl/snz_power_chk.sv
module snz_power_chk #(
    parameter int CTL_W       = 8,
    parameter int RECOVER_CYC = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snooze_sync,
    input logic             sleep_flag,
    input logic             gate_en,
    input logic             start_inhibit,
    input logic             start_pass_a,
    input logic             start_pass_b,
    input logic [CTL_W-1:0] ctl_pass,
    input logic             dq_drive
);
    localparam int RW = $clog2(RECOVER_CYC + 2);
    logic [RW-1:0] rec_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rec_cnt <= '0;
        else if (sleep_flag || !start_inhibit) rec_cnt <= '0;
        else if (rec_cnt != '1)              rec_cnt <= rec_cnt + 1'b1;
    end

    // R4
    sleep_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_flag |-> (!gate_en && !start_pass_a && !start_pass_b && !dq_drive && ctl_pass == '0));

    // R2
    entry_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_flag) |-> $past(snooze_sync));

    // R5
    wake_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_flag) |-> !$past(snooze_sync));

    // R6
    recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_flag) |-> start_inhibit);

    // R6
    recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_inhibit) |-> rec_cnt == RW'(RECOVER_CYC));
endmodule

bind snz_power_ctl snz_power_chk #(.CTL_W(CTL_W), .RECOVER_CYC(RECOVER_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .snooze_sync   (snooze_sync),
    .sleep_flag    (sleep_flag),
    .gate_en       (gate_en),
    .start_inhibit (start_inhibit),
    .start_pass_a  (start_pass_a),
    .start_pass_b  (start_pass_b),
    .ctl_pass      (ctl_pass),
    .dq_drive      (dq_drive)
);

// File: tb/tb_snz_power_ctl.sv
module tb_snz_power_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snooze_in = 1'b0;
    logic       oe_in = 1'b0;
    logic       strobe_a = 1'b0;
    logic       strobe_b = 1'b0;
    logic [7:0] ctl_in = 8'h00;
    logic       sleep_flag, gate_en, start_inhibit, start_pass_a, start_pass_b, dq_drive;
    logic [7:0] ctl_pass;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    snz_power_ctl dut (
        .clk(clk), .rst_n(rst_n), .snooze_in(snooze_in), .oe_in(oe_in),
        .strobe_a(strobe_a), .strobe_b(strobe_b), .ctl_in(ctl_in),
        .sleep_flag(sleep_flag), .gate_en(gate_en), .start_inhibit(start_inhibit),
        .start_pass_a(start_pass_a), .start_pass_b(start_pass_b),
        .ctl_pass(ctl_pass), .dq_drive(dq_drive)
    );

    // status = {sleep, gate, inhibit, drive, pass_a, pass_b, ctl_pass[7:0]}
    typedef struct packed {
        logic        snz;
        logic        oe;
        logic        stb;
        logic [7:0]  ctl;
        logic [7:0]  wait_n;
        logic [3:0]  req;
        logic [13:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 8'hA5, 8'd1, 4'd8, {6'b010111, 8'hA5}},  // R8 awake passthrough
        '{1'b1, 1'b1, 1'b0, 8'h3C, 8'd8, 4'd2, {6'b010100, 8'h3C}},  // R2 one edge before entry
        '{1'b1, 1'b1, 1'b1, 8'hFF, 8'd1, 4'd2, {6'b101000, 8'h00}},  // R2 asleep on 9th edge
        '{1'b1, 1'b0, 1'b1, 8'h0F, 8'd3, 4'd4, {6'b101000, 8'h00}},  // R4 isolation holds
        '{1'b0, 1'b1, 1'b1, 8'h11, 8'd8, 4'd5, {6'b101000, 8'h00}},  // R5 one edge before wake
        '{1'b0, 1'b1, 1'b1, 8'h22, 8'd1, 4'd6, {6'b011100, 8'h22}},  // R6 recovery starts
        '{1'b0, 1'b1, 1'b1, 8'h22, 8'd9, 4'd6, {6'b011100, 8'h22}},  // R6 last lockout cycle
        '{1'b0, 1'b1, 1'b1, 8'h22, 8'd1, 4'd6, {6'b010111, 8'h22}}   // R6 lockout released
    };

    function automatic logic [13:0] status();
        return {sleep_flag, gate_en, start_inhibit, dq_drive, start_pass_a, start_pass_b, ctl_pass};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        #1;
        check("R1", {sleep_flag, gate_en, start_inhibit, 11'b0}, 14'b01000000000000);
        step(3);
        rst_n = 1'b1;
        step(1);

        for (int i = 0; i < NV; i++) begin
            snooze_in = VECS[i].snz;
            oe_in     = VECS[i].oe;
            strobe_a  = VECS[i].stb;
            strobe_b  = VECS[i].stb;
            ctl_in    = VECS[i].ctl;
            step(int'(VECS[i].wait_n));
            check($sformatf("R%0d vec%0d", VECS[i].req, i), status(), VECS[i].exp);
        end

        // R7 snooze raised during recovery
        snooze_in = 1'b1;
        step(9);
        snooze_in = 1'b0;
        step(9);
        check("R7 recovery entered", {sleep_flag, start_inhibit, 12'b0}, {2'b01, 12'b0});
        snooze_in = 1'b1;
        step(9);
        check("R7 still locked", {sleep_flag, start_inhibit, 12'b0}, {2'b01, 12'b0});
        step(1);
        check("R7 lockout ends on time", {sleep_flag, start_inhibit, 12'b0}, {2'b00, 12'b0});
        step(7);
        check("R7 entry follows", {sleep_flag, gate_en, 12'b0}, {2'b10, 12'b0});

        // R5 short low pulse keeps sleep
        snooze_in = 1'b0;
        step(5);
        snooze_in = 1'b1;
        step(10);
        check("R5 short wake pulse", {sleep_flag, gate_en, start_inhibit, 11'b0}, {3'b101, 11'b0});

        // R4 isolation with oe low and high
        oe_in = 1'b1; strobe_a = 1'b1; strobe_b = 1'b1; ctl_in = 8'h5A;
        #1;
        check("R4 oe high asleep", status(), {6'b101000, 8'h00});

        // R1 reset while asleep
        rst_n = 1'b0;
        #1;
        check("R1 reset mid sleep", {sleep_flag, gate_en, start_inhibit, 11'b0}, {3'b010, 11'b0});
        snooze_in = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);

        // R3 short high pulse leaves block awake
        snooze_in = 1'b1;
        step(5);
        snooze_in = 1'b0;
        step(10);
        check("R3 short sleep pulse", {sleep_flag, gate_en, start_inhibit, 11'b0}, {3'b010, 11'b0});

        // R8 awake with oe low and one strobe
        oe_in = 1'b0; strobe_a = 1'b0; strobe_b = 1'b1; ctl_in = 8'hC3;
        #1;
        check("R8 awake mix", status(), {6'b010001, 8'hC3});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule